// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This block is the central bookkeeping and decision logic for a small floating-point pipeline that issues in program order and completes out of order. Each cycle it is offered at most one decoded instruction (an operation class, a destination register and two source register numbers). It keeps one status entry per functional unit (adder, multiplier, divider) and a result-status table that maps each architectural register to the unit that will produce it. From these tables it decides, every cycle, whether the offered instruction may issue, which units may read their operands, and which unit may write its result.

Execution is not performed here. Each unit is modelled as a countdown timer loaded when its operands are read. The block applies the classic four-step rules: issue, read operands, execute, write result. It uses no forwarding and no renaming. Structural and write-after-write conflicts stall issue. Read-after-write dependences delay operand read. Write-after-read conflicts delay the write of a result. The surrounding pipeline holds the offered instruction while `stall` is high, and it reads its operands and performs write-backs when the grant signals say so.

Top module: `sb_scoreboard`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, all units are free. `rd_grant` and `wb_grant` are zero, and an offered instruction is not stalled.
- R2: Operation encoding: 0 add and 1 subtract go to the adder (unit 0), 2 multiply goes to the multiplier (unit 1), and 3 divide goes to the divider (unit 2). An offered instruction whose unit is free, and whose destination has no pending writer, raises `issue_fire` with `stall` low in that same cycle.
- R3: An offered instruction whose unit is busy raises `stall` and does not issue. For example, a subtract offered while an add is still in flight is stalled.
- R4: An offered instruction whose destination register already has a pending writer raises `stall` and does not issue.
- R5: A unit whose sources have no pending writer is granted its operand read (`rd_grant` bit) in the cycle after issue. A unit waiting on a producer is granted its read in the cycle after that producer's write-back. A write-back in the issue cycle counts as already done.
- R6: A unit's write-back is requested exactly LAT+1 cycles after its read grant, where LAT is 2 for the adder, 10 for the multiplier and 40 for the divider.
- R7: A unit may not write back while another busy unit holds an operand flagged ready-but-unread whose source register equals the writing unit's destination.
- R8: At most one `wb_grant` bit is high per cycle. Among eligible units the lowest index wins, so the divider has the lowest priority. `wb_reg` and `wb_op` give the destination and operation of the granted write.
- R9: A write-back frees its unit and clears the register's pending writer, so a new instruction for that unit or register can issue in the next cycle.
- R10: Each issued instruction receives exactly one read grant, a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_op | input | 2 | Operation class (0 add, 1 sub, 2 mul, 3 div) |
| in_dst | input | REG_W | Destination register number |
| in_src1 | input | REG_W | First source register number |
| in_src2 | input | REG_W | Second source register number |
| stall | output | 1 | Offered instruction cannot issue this cycle |
| issue_fire | output | 1 | Offered instruction issues this cycle |
| rd_grant | output | 3 | Per-unit operand-read grant |
| wb_grant | output | 3 | Per-unit write-back grant, one-hot or zero |
| wb_reg | output | REG_W | Destination register of the granted write-back |
| wb_op | output | 2 | Operation of the granted write-back |

## Verification
The bench targets write-backs that land in the same cycle as the issue of a consumer. A design without the issue-time bypass would record a tag that is never broadcast again, and the consumer would never read its operands. It also targets write-after-read windows, where a late reader still needs the old value: a design that ignored them would let a fast add overwrite a register before an earlier slow consumer has read it. Other targets are simultaneous completions, where a wrong priority or a missing one-hot guard would grant two write-backs or favour the divider, and release timing, where an off-by-one would stall a structurally free unit for an extra cycle or move the completion cycles of the dependent sequence away from 12, 13, 16 and 17.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NFU  = 3;
  localparam int FU_W = 2;

  localparam int FU_ADDER = 0;
  localparam int FU_MULT  = 1;
  localparam int FU_DIVR  = 2;

  typedef enum logic [1:0] {
    OPC_ADD = 2'd0,
    OPC_SUB = 2'd1,
    OPC_MUL = 2'd2,
    OPC_DIV = 2'd3
  } opc_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_EXEC = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  // Map an operation class onto the unit that executes it.
  function automatic logic [FU_W-1:0] unit_of(input logic [1:0] op);
    case (op)
      OPC_ADD, OPC_SUB: unit_of = FU_W'(FU_ADDER);
      OPC_MUL:          unit_of = FU_W'(FU_MULT);
      default:          unit_of = FU_W'(FU_DIVR);
    endcase
  endfunction

  // A tag is live only if no write-back of that same unit retires it now.
  function automatic logic tag_live(input logic pend, input logic [FU_W-1:0] tag,
                                    input logic wb_fire, input logic [FU_W-1:0] wb_idx);
    tag_live = pend && !(wb_fire && (tag == wb_idx));
  endfunction
endpackage

// File: rtl/sb_unit_entry.sv
module sb_unit_entry import sb_pkg::*; #(
  parameter int REG_W = 3,
  parameter int CNT_W = 6,
  parameter int LAT   = 2,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [1:0]       alloc_op,
  input  logic [REG_W-1:0] alloc_fi,
  input  logic [REG_W-1:0] alloc_fj,
  input  logic [REG_W-1:0] alloc_fk,
  input  logic             alloc_qj_vld,
  input  logic [FU_W-1:0]  alloc_qj,
  input  logic             alloc_qk_vld,
  input  logic [FU_W-1:0]  alloc_qk,
  input  logic             wb_fire,
  input  logic [FU_W-1:0]  wb_idx,
  output logic             busy,
  output logic             rd_req,
  output logic             done,
  output logic [1:0]       op,
  output logic [REG_W-1:0] fi,
  output logic [REG_W-1:0] fj,
  output logic [REG_W-1:0] fk,
  output logic             rj,
  output logic             rk
);
  phase_e          phase;
  logic [CNT_W-1:0] cnt;
  logic            qj_vld, qk_vld;
  logic [FU_W-1:0] qj, qk;
  logic            release_me;
  logic            hit_j, hit_k;

  assign busy       = (phase != PH_IDLE);
  assign rd_req     = (phase == PH_WAIT) && rj && rk;
  assign done       = (phase == PH_DONE);
  assign release_me = wb_fire && (wb_idx == FU_W'(IDX));
  assign hit_j      = wb_fire && qj_vld && (qj == wb_idx);
  assign hit_k      = wb_fire && qk_vld && (qk == wb_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      op     <= '0;
      fi     <= '0;
      fj     <= '0;
      fk     <= '0;
      qj     <= '0;
      qk     <= '0;
      qj_vld <= 1'b0;
      qk_vld <= 1'b0;
      rj     <= 1'b0;
      rk     <= 1'b0;
    end else if (alloc) begin
      phase  <= PH_WAIT;
      op     <= alloc_op;
      fi     <= alloc_fi;
      fj     <= alloc_fj;
      fk     <= alloc_fk;
      qj     <= alloc_qj;
      qk     <= alloc_qk;
      qj_vld <= alloc_qj_vld;
      qk_vld <= alloc_qk_vld;
      rj     <= !alloc_qj_vld;
      rk     <= !alloc_qk_vld;
    end else begin
      case (phase)
        PH_WAIT: begin
          if (rd_req) begin
            phase <= PH_EXEC;
            cnt   <= CNT_W'(LAT);
            rj    <= 1'b0;
            rk    <= 1'b0;
          end else begin
            if (hit_j) begin
              rj     <= 1'b1;
              qj_vld <= 1'b0;
            end
            if (hit_k) begin
              rk     <= 1'b1;
              qk_vld <= 1'b0;
            end
          end
        end
        PH_EXEC: begin
          if (cnt == CNT_W'(1)) phase <= PH_DONE;
          else                  cnt   <= cnt - CNT_W'(1);
        end
        PH_DONE: begin
          if (release_me) phase <= PH_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sb_result_status.sv
module sb_result_status import sb_pkg::*; #(
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic [FU_W-1:0]  set_tag,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_reg,
  input  logic [REG_W-1:0] look_a,
  input  logic [REG_W-1:0] look_b,
  input  logic [REG_W-1:0] look_c,
  output logic             a_pend,
  output logic [FU_W-1:0]  a_tag,
  output logic             b_pend,
  output logic [FU_W-1:0]  b_tag,
  output logic             c_pend
);
  localparam int NREG = 1 << REG_W;

  logic [NREG-1:0] pend;
  logic [FU_W-1:0] tag [NREG];

  assign a_pend = pend[look_a];
  assign a_tag  = tag[look_a];
  assign b_pend = pend[look_b];
  assign b_tag  = tag[look_b];
  assign c_pend = pend[look_c];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      for (int r = 0; r < NREG; r++) tag[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (set_en && (set_reg == REG_W'(r))) begin
          pend[r] <= 1'b1;
          tag[r]  <= set_tag;
        end else if (clr_en && (clr_reg == REG_W'(r))) begin
          pend[r] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter import sb_pkg::*; (
  input  logic [NFU-1:0]  done_vec,
  input  logic [NFU-1:0]  war_vec,
  output logic [NFU-1:0]  grant,
  output logic            fire,
  output logic [FU_W-1:0] idx
);
  // Scan from the highest index down so the lowest eligible index wins.
  always_comb begin
    grant = '0;
    fire  = 1'b0;
    idx   = '0;
    for (int i = NFU - 1; i >= 0; i--) begin
      if (done_vec[i] && !war_vec[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        fire     = 1'b1;
        idx      = FU_W'(i);
      end
    end
  end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard import sb_pkg::*; #(
  parameter int REG_W   = 3,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src1,
  input  logic [REG_W-1:0] in_src2,
  output logic             stall,
  output logic             issue_fire,
  output logic [NFU-1:0]   rd_grant,
  output logic [NFU-1:0]   wb_grant,
  output logic [REG_W-1:0] wb_reg,
  output logic [1:0]       wb_op
);
  localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ?
                           ((LAT_DIV > LAT_ADD) ? LAT_DIV : LAT_ADD) :
                           ((LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD);
  localparam int CNT_W = $clog2(LAT_MAX + 1);

  // Named internal events, shared with the bound checker.
  logic [FU_W-1:0]  issue_unit;
  logic             dst_pend;
  logic             s1_pend, s2_pend;
  logic [FU_W-1:0]  s1_tag, s2_tag;
  logic             s1_wait, s2_wait;
  logic [NFU-1:0]   unit_busy;
  logic [NFU-1:0]   done_vec;
  logic [NFU-1:0]   war_vec;
  logic             wb_fire;
  logic [FU_W-1:0]  wb_idx;

  logic [1:0]       u_op [NFU];
  logic [REG_W-1:0] u_fi [NFU];
  logic [REG_W-1:0] u_fj [NFU];
  logic [REG_W-1:0] u_fk [NFU];
  logic             u_rj [NFU];
  logic             u_rk [NFU];

  assign issue_unit = unit_of(in_op);
  assign stall      = in_valid && (unit_busy[issue_unit] || dst_pend);
  assign issue_fire = in_valid && !stall;
  assign s1_wait    = tag_live(s1_pend, s1_tag, wb_fire, wb_idx);
  assign s2_wait    = tag_live(s2_pend, s2_tag, wb_fire, wb_idx);

  sb_result_status #(.REG_W(REG_W)) u_rstat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (issue_fire),
    .set_reg (in_dst),
    .set_tag (issue_unit),
    .clr_en  (wb_fire),
    .clr_reg (wb_reg),
    .look_a  (in_src1),
    .look_b  (in_src2),
    .look_c  (in_dst),
    .a_pend  (s1_pend),
    .a_tag   (s1_tag),
    .b_pend  (s2_pend),
    .b_tag   (s2_tag),
    .c_pend  (dst_pend)
  );

  for (genvar g = 0; g < NFU; g++) begin : g_unit
    localparam int LAT_G = (g == FU_ADDER) ? LAT_ADD :
                           (g == FU_MULT)  ? LAT_MUL : LAT_DIV;
    sb_unit_entry #(
      .REG_W (REG_W),
      .CNT_W (CNT_W),
      .LAT   (LAT_G),
      .IDX   (g)
    ) u_entry (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc        (issue_fire && (issue_unit == FU_W'(g))),
      .alloc_op     (in_op),
      .alloc_fi     (in_dst),
      .alloc_fj     (in_src1),
      .alloc_fk     (in_src2),
      .alloc_qj_vld (s1_wait),
      .alloc_qj     (s1_tag),
      .alloc_qk_vld (s2_wait),
      .alloc_qk     (s2_tag),
      .wb_fire      (wb_fire),
      .wb_idx       (wb_idx),
      .busy         (unit_busy[g]),
      .rd_req       (rd_grant[g]),
      .done         (done_vec[g]),
      .op           (u_op[g]),
      .fi           (u_fi[g]),
      .fj           (u_fj[g]),
      .fk           (u_fk[g]),
      .rj           (u_rj[g]),
      .rk           (u_rk[g])
    );
  end

  // Write-after-read: another unit still has an unread operand naming our target.
  always_comb begin
    for (int f = 0; f < NFU; f++) begin
      war_vec[f] = 1'b0;
      for (int g = 0; g < NFU; g++) begin
        if ((g != f) && unit_busy[g] &&
            (((u_fj[g] == u_fi[f]) && u_rj[g]) || ((u_fk[g] == u_fi[f]) && u_rk[g])))
          war_vec[f] = 1'b1;
      end
    end
  end

  sb_wb_arbiter u_arb (
    .done_vec (done_vec),
    .war_vec  (war_vec),
    .grant    (wb_grant),
    .fire     (wb_fire),
    .idx      (wb_idx)
  );

  always_comb begin
    wb_reg = '0;
    wb_op  = '0;
    for (int f = 0; f < NFU; f++) begin
      if (wb_grant[f]) begin
        wb_reg = u_fi[f];
        wb_op  = u_op[f];
      end
    end
  end
endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk import sb_pkg::*; (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [1:0]     in_op,
  input logic           stall,
  input logic           issue_fire,
  input logic [NFU-1:0] rd_grant,
  input logic [NFU-1:0] wb_grant,
  input logic [NFU-1:0] u_busy,
  input logic           dst_pend,
  input logic [NFU-1:0] war_vec
);
  logic [FU_W-1:0] chk_unit;
  assign chk_unit = unit_of(in_op);

  AST_ONE_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_grant)); // R8
  AST_STRUCT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && u_busy[chk_unit]) |-> stall); // R3
  AST_WAW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_pend) |-> stall); // R4
  AST_ISSUE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> (in_valid && !stall)); // R2
  AST_WB_NOT_WAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|wb_grant) |-> ((wb_grant & war_vec) == '0)); // R7

  for (genvar f = 0; f < NFU; f++) begin : g_chk
    AST_WB_FREES_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      wb_grant[f] |=> !u_busy[f]); // R9
    AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant[f] |=> !rd_grant[f]); // R10
    AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_grant[f] |-> u_busy[f]); // R5
  end
endmodule

bind sb_scoreboard sb_scoreboard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .stall      (stall),
  .issue_fire (issue_fire),
  .rd_grant   (rd_grant),
  .wb_grant   (wb_grant),
  .u_busy     (unit_busy),
  .dst_pend   (dst_pend),
  .war_vec    (war_vec)
);

// File: tb/sb_scoreboard_tb.sv
module sb_scoreboard_tb;
  localparam int NPROG = 70;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_op = '0;
  logic [2:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic       stall, issue_fire;
  logic [2:0] rd_grant, wb_grant;
  logic [2:0] wb_reg;
  logic [1:0] wb_op;

  always #4 clk = ~clk;

  sb_scoreboard u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .stall(stall), .issue_fire(issue_fire), .rd_grant(rd_grant),
    .wb_grant(wb_grant), .wb_reg(wb_reg), .wb_op(wb_op)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: one record per unit slot, integers, -1 for "none".
  int lat [3] = '{2, 10, 40};
  int m_ph [3], m_cnt [3], m_op [3], m_fi [3], m_fj [3], m_fk [3];
  int m_qj [3], m_qk [3], m_rj [3], m_rk [3];
  int m_reg [8];

  int p_op [NPROG], p_d [NPROG], p_a [NPROG], p_b [NPROG];

  function automatic int unit_for(input int op);
    return (op < 2) ? 0 : op - 1;
  endfunction

  initial begin
    int ptr, cyc, drain;
    int t_mulwb, t_addrd, t_addwb, t_subiss;
    bit stall_rel2;
    bit hung;

    for (int i = 0; i < 3; i++) m_ph[i] = 0;
    for (int r = 0; r < 8; r++) m_reg[r] = -1;

    // Directed dependent prefix, then a pseudo-random stream.
    p_op[0] = 2; p_d[0] = 1; p_a[0] = 2; p_b[0] = 3;   // mul r1 = r2*r3
    p_op[1] = 0; p_d[1] = 4; p_a[1] = 1; p_b[1] = 2;   // add r4 = r1+r2
    p_op[2] = 1; p_d[2] = 5; p_a[2] = 2; p_b[2] = 3;   // sub r5 = r2-r3
    for (int i = 3; i < NPROG; i++) begin
      p_op[i] = ($urandom_range(0, 9) < 7) ? $urandom_range(0, 1) : $urandom_range(2, 3);
      p_d[i]  = $urandom_range(0, 7);
      p_a[i]  = $urandom_range(0, 7);
      p_b[i]  = $urandom_range(0, 7);
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    check(rd_grant == 3'b000, "R1", "rd_grant in reset", int'(rd_grant), 0);
    check(wb_grant == 3'b000, "R1", "wb_grant in reset", int'(wb_grant), 0);
    in_valid = 1'b1; in_op = 2'd3; in_dst = 3'd0;
    #1;
    check(stall == 1'b0, "R1", "stall in reset", int'(stall), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    ptr = 0; cyc = 0; drain = 0; hung = 0;
    t_mulwb = -1; t_addrd = -1; t_addwb = -1; t_subiss = -1; stall_rel2 = 0;

    while (1) begin
      int u, e_stall, e_iss, wsel, e_wreg, e_wop;
      int e_rd [3];
      bit v;
      v = (ptr < NPROG);
      in_valid = v;
      if (v) begin
        in_op = 2'(p_op[ptr]); in_dst = 3'(p_d[ptr]);
        in_src1 = 3'(p_a[ptr]); in_src2 = 3'(p_b[ptr]);
      end
      #1;
      u = unit_for(int'(in_op));
      e_stall = (v && (m_ph[u] != 0 || m_reg[in_dst] >= 0)) ? 1 : 0;
      e_iss   = (v && e_stall == 0) ? 1 : 0;
      for (int f = 0; f < 3; f++) e_rd[f] = (m_ph[f] == 1 && m_rj[f] != 0 && m_rk[f] != 0) ? 1 : 0;
      wsel = -1;
      for (int f = 0; f < 3; f++) begin
        if (wsel < 0 && m_ph[f] == 3) begin
          bit blk;
          blk = 0;
          for (int g = 0; g < 3; g++)
            if (g != f && m_ph[g] != 0 &&
                ((m_fj[g] == m_fi[f] && m_rj[g] != 0) || (m_fk[g] == m_fi[f] && m_rk[g] != 0)))
              blk = 1;
          if (!blk) wsel = f;
        end
      end
      e_wreg = (wsel >= 0) ? m_fi[wsel] : 0;
      e_wop  = (wsel >= 0) ? m_op[wsel] : 0;

      check(int'(stall) == e_stall, "R3 R4 R9", "stall", int'(stall), e_stall);
      check(int'(issue_fire) == e_iss, "R2", "issue_fire", int'(issue_fire), e_iss);
      for (int f = 0; f < 3; f++)
        check(int'(rd_grant[f]) == e_rd[f], "R5 R10", "rd_grant bit", int'(rd_grant[f]), e_rd[f]);
      for (int f = 0; f < 3; f++)
        check(int'(wb_grant[f]) == ((wsel == f) ? 1 : 0), "R6 R7 R8", "wb_grant bit",
              int'(wb_grant[f]), (wsel == f) ? 1 : 0);
      check(int'(wb_reg) == e_wreg, "R8", "wb_reg", int'(wb_reg), e_wreg);
      check(int'(wb_op) == e_wop, "R8", "wb_op", int'(wb_op), e_wop);

      // Event capture for the directed sequence
      if (cyc == 2 && stall) stall_rel2 = 1;
      if (wb_grant[1] && t_mulwb < 0) t_mulwb = cyc;
      if (rd_grant[0] && t_addrd < 0) t_addrd = cyc;
      if (wb_grant[0] && t_addwb < 0) t_addwb = cyc;
      if (issue_fire && ptr == 2) t_subiss = cyc;

      // Advance reference state to the next edge
      for (int f = 0; f < 3; f++) begin
        if (m_ph[f] == 2) begin
          if (m_cnt[f] == 1) m_ph[f] = 3;
          else m_cnt[f]--;
        end else if (e_rd[f] != 0) begin
          m_ph[f] = 2; m_cnt[f] = lat[f]; m_rj[f] = 0; m_rk[f] = 0;
        end
      end
      if (wsel >= 0) begin
        for (int g = 0; g < 3; g++) begin
          if (m_ph[g] == 1) begin
            if (m_qj[g] == wsel) begin m_rj[g] = 1; m_qj[g] = -1; end
            if (m_qk[g] == wsel) begin m_rk[g] = 1; m_qk[g] = -1; end
          end
        end
        m_reg[m_fi[wsel]] = -1;
        m_ph[wsel] = 0;
      end
      if (e_iss != 0) begin
        m_ph[u] = 1; m_op[u] = int'(in_op); m_fi[u] = int'(in_dst);
        m_fj[u] = int'(in_src1); m_fk[u] = int'(in_src2);
        m_qj[u] = m_reg[in_src1]; m_qk[u] = m_reg[in_src2];
        m_rj[u] = (m_qj[u] < 0) ? 1 : 0; m_rk[u] = (m_qk[u] < 0) ? 1 : 0;
        m_reg[in_dst] = u;
        ptr++;
      end

      cyc++;
      if (ptr >= NPROG && m_ph[0] == 0 && m_ph[1] == 0 && m_ph[2] == 0) drain++;
      if (drain > 4) break;
      if (cyc > 20000) begin hung = 1; break; end
      @(negedge clk);
    end
    in_valid = 1'b0;

    check(!hung, "R6", "watchdog", cyc, 20000);
    check(stall_rel2, "R3", "sub stalled behind add", int'(stall_rel2), 1);
    check(t_mulwb == 12, "R6", "mul write-back cycle", t_mulwb, 12);
    check(t_addrd == 13, "R5", "dependent add read cycle", t_addrd, 13);
    check(t_addwb == 16, "R6", "add write-back cycle", t_addwb, 16);
    check(t_subiss == 17, "R9", "sub issue after adder freed", t_subiss, 17);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule